// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This block turns byte-wide requests from a processor core into cycles on an 8051-style external bus. Two byte-wide ports do the work. The low port carries the low address byte and then the data byte. The upper port carries the upper address bits. An address strobe marks the cycles in which outside latches must capture the address. For data accesses the upper port first presents a page byte, which is captured with the strobe, and then the pointer high byte. This gives a 24-bit data address. A plain 16-bit memory with no page latch still works unchanged.

Code fetches use a 16-bit address and go to one of two places. A strap level, captured during reset, selects between them. With the strap high, fetches read a synchronous on-chip code memory through a separate port, and any address above 0xF7FF returns the opcode byte 0x00 without a memory access. With the strap low, every fetch runs a full cycle on the external bus.

The core raises a one-cycle request while the controller is idle. When the access finishes, the controller returns a one-cycle done pulse together with the byte it read. All bus and response outputs come straight from flip-flops, and every bus phase lasts a fixed, parameterised number of clock cycles.

Top module: `xbus_ctrl`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `ale` and `lo_oe` are 0, `rd_n`, `wr_n` and `psen_n` are 1, and `busy`, `rsp_valid` and `icode_en` are 0.
- R2: A request is accepted only on a clock edge where `busy` is 0. If `data_req` and `fetch_req` are both high, only the data request is served and the fetch is dropped. Requests raised while `busy` is 1 are dropped and cause no bus activity. `busy` goes high the cycle after acceptance and stays high through the done cycle.
- R3: An external access begins with ADDR_CYC cycles in which `ale` is 1, `lo_oe` is 1 and `lo_out` carries address bits 7:0. During these cycles `hi_out` carries bits 15:8 for a code fetch and bits 23:16 (the page byte) for a data access. Code fetches never place a page byte on the bus.
- R4: After the address cycles, `hi_out` carries address bits 15:8 through the turnaround and data cycles, for all external access types.
- R5: After the address cycles, `lo_oe` is 0 for TURN_CYC (at least 1) cycles. For reads and external fetches it stays 0 through the data cycles, and `lo_in` is sampled on the clock edge that ends the last data cycle.
- R6: For a data write, `lo_oe` is 1 and `lo_out` holds the write byte for all DATA_CYC data cycles.
- R7: In the data cycles, exactly one strobe is low: `psen_n` for an external fetch, `rd_n` for a data read, `wr_n` for a data write. It is low for exactly DATA_CYC cycles. Two strobes are never low together, and no strobe is low while `ale` is 1.
- R8: `rsp_valid` is a one-cycle pulse in the cycle after the last data cycle. For a read or fetch, `rsp_data` then holds the sampled byte.
- R9: The level of `strap_int` is captured while `rst` is high: 1 selects on-chip code, 0 selects external code. Changes to `strap_int` after reset have no effect.
- R10: An on-chip fetch at an address up to 0xF7FF raises `icode_en` for one cycle with `icode_addr` equal to the address, in the cycle after acceptance. It takes `icode_rdata` one cycle later and gives `rsp_valid` three cycles after acceptance. The external bus stays idle.
- R11: An on-chip fetch above 0xF7FF gives `rsp_valid` with `rsp_data` = 0x00 in the cycle after acceptance. It raises no `icode_en` and causes no bus activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_int | input | 1 | Code-space strap, captured during reset (1 = on-chip) |
| fetch_req | input | 1 | Code fetch request pulse |
| fetch_addr | input | 16 | Code fetch address |
| data_req | input | 1 | Data access request pulse |
| data_we | input | 1 | 1 = data write, 0 = data read |
| data_ptr | input | 24 | Data address {page, high, low} |
| data_wdata | input | 8 | Write byte |
| busy | output | 1 | Access in progress |
| rsp_valid | output | 1 | Done pulse |
| rsp_data | output | 8 | Byte returned by a read or fetch |
| icode_en | output | 1 | On-chip code memory read enable |
| icode_addr | output | 16 | On-chip code memory address |
| icode_rdata | input | 8 | On-chip code memory data, one cycle after enable |
| ale | output | 1 | Address latch strobe |
| lo_out | output | 8 | Low port output value |
| lo_oe | output | 1 | Low port output enable |
| lo_in | input | 8 | Low port input value |
| hi_out | output | 8 | Upper address port |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| psen_n | output | 1 | External code read strobe, active low |

## Verification
Every pin is decoded afresh from the phase register on each cycle. A wrong phase, a wrong counter value or a wrong stored request therefore shows up on `ale`, `lo_oe`, a strobe or `hi_out` on the very next clock. The bench compares every output against a behavioural schedule on every cycle. A wrongly captured strap or address shows up one access later as the wrong bus pattern or response byte. Writes go into a bench-side bus memory and are then read back, so a bad write byte or a bad page byte surfaces on the read response.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  localparam int BYTE_W  = 8;
  localparam int CODE_AW = 16;
  localparam int DATA_AW = 24;

  typedef enum logic [2:0] {
    PH_IDLE, PH_ADDR, PH_TURN, PH_DATA, PH_IROM, PH_IWAIT, PH_RESP
  } xbus_phase_e;

  typedef enum logic [2:0] {
    K_NONE, K_ICODE, K_NOP, K_XCODE, K_DRD, K_DWR
  } xbus_kind_e;

  typedef struct packed {
    xbus_kind_e          kind;
    logic [DATA_AW-1:0]  addr;
    logic [BYTE_W-1:0]   wdata;
  } xbus_op_t;
endpackage

// File: rtl/xbus_req_arb.sv
module xbus_req_arb
  import xbus_pkg::*;
#(
  parameter logic [CODE_AW-1:0] IROM_TOP = 16'hF7FF
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               strap_int,
  input  logic               idle,
  input  logic               fetch_req,
  input  logic [CODE_AW-1:0] fetch_addr,
  input  logic               data_req,
  input  logic               data_we,
  input  logic [DATA_AW-1:0] data_ptr,
  input  logic [BYTE_W-1:0]  data_wdata,
  output logic               start,
  output xbus_op_t           op
);
  logic strap_q;

  // strap level is only taken while reset is held
  always_ff @(posedge clk) begin
    if (rst) strap_q <= strap_int;
  end

  always_comb begin
    op.kind  = K_NONE;
    op.addr  = '0;
    op.wdata = '0;
    if (data_req) begin
      op.kind  = data_we ? K_DWR : K_DRD;
      op.addr  = data_ptr;
      op.wdata = data_wdata;
    end else if (fetch_req) begin
      op.addr = {{(DATA_AW-CODE_AW){1'b0}}, fetch_addr};
      if (!strap_q)                  op.kind = K_XCODE;
      else if (fetch_addr > IROM_TOP) op.kind = K_NOP;
      else                           op.kind = K_ICODE;
    end
  end

  assign start = idle && !rst && (data_req || fetch_req);
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_pkg::*;
#(
  parameter int ADDR_CYC = 2,
  parameter int TURN_CYC = 1,
  parameter int DATA_CYC = 3
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  xbus_kind_e  start_kind,
  output xbus_phase_e phase_q,
  output xbus_phase_e phase_d,
  output logic        idle
);
  localparam int MAX_AT = (ADDR_CYC > TURN_CYC) ? ADDR_CYC : TURN_CYC;
  localparam int MAX_C  = (MAX_AT > DATA_CYC) ? MAX_AT : DATA_CYC;
  localparam int CW     = (MAX_C > 1) ? $clog2(MAX_C) : 1;
  localparam logic [CW-1:0] A_LAST = CW'(ADDR_CYC - 1);
  localparam logic [CW-1:0] T_LAST = CW'(TURN_CYC - 1);
  localparam logic [CW-1:0] D_LAST = CW'(DATA_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = (cnt_q != '0) ? cnt_q - 1'b1 : cnt_q;
    unique case (phase_q)
      PH_IDLE: if (start) begin
        unique case (start_kind)
          K_ICODE: phase_d = PH_IROM;
          K_NOP:   phase_d = PH_RESP;
          default: begin phase_d = PH_ADDR; cnt_d = A_LAST; end
        endcase
      end
      PH_ADDR:  if (cnt_q == '0) begin phase_d = PH_TURN; cnt_d = T_LAST; end
      PH_TURN:  if (cnt_q == '0) begin phase_d = PH_DATA; cnt_d = D_LAST; end
      PH_DATA:  if (cnt_q == '0) phase_d = PH_RESP;
      PH_IROM:  phase_d = PH_IWAIT;
      PH_IWAIT: phase_d = PH_RESP;
      PH_RESP:  phase_d = PH_IDLE;
      default:  phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  assign idle = (phase_q == PH_IDLE);
endmodule

// File: rtl/xbus_pins.sv
module xbus_pins
  import xbus_pkg::*;
#(
  parameter logic [BYTE_W-1:0] NOP_BYTE = 8'h00
) (
  input  logic               clk,
  input  logic               rst,
  input  xbus_phase_e        phase_q,
  input  xbus_phase_e        phase_d,
  input  xbus_op_t           op,
  input  logic [BYTE_W-1:0]  lo_in,
  input  logic [BYTE_W-1:0]  icode_rdata,
  output logic               busy,
  output logic               rsp_valid,
  output logic [BYTE_W-1:0]  rsp_data,
  output logic               icode_en,
  output logic [CODE_AW-1:0] icode_addr,
  output logic               ale,
  output logic [BYTE_W-1:0]  lo_out,
  output logic               lo_oe,
  output logic [BYTE_W-1:0]  hi_out,
  output logic               rd_n,
  output logic               wr_n,
  output logic               psen_n
);
  logic in_addr, in_mid, in_data, is_wr, is_rd, is_xc;

  assign in_addr = (phase_d == PH_ADDR);
  assign in_mid  = (phase_d == PH_TURN) || (phase_d == PH_DATA);
  assign in_data = (phase_d == PH_DATA);
  assign is_wr   = (op.kind == K_DWR);
  assign is_rd   = (op.kind == K_DRD);
  assign is_xc   = (op.kind == K_XCODE);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_data   <= '0;
      icode_en   <= 1'b0;
      icode_addr <= '0;
      ale        <= 1'b0;
      lo_out     <= '0;
      lo_oe      <= 1'b0;
      hi_out     <= '0;
      rd_n       <= 1'b1;
      wr_n       <= 1'b1;
      psen_n     <= 1'b1;
    end else begin
      busy      <= (phase_d != PH_IDLE);
      rsp_valid <= (phase_d == PH_RESP);
      icode_en  <= (phase_d == PH_IROM);
      if (phase_d == PH_IROM) icode_addr <= op.addr[CODE_AW-1:0];

      ale   <= in_addr;
      lo_oe <= in_addr || (in_data && is_wr);
      if (in_addr)               lo_out <= op.addr[7:0];
      else if (in_data && is_wr) lo_out <= op.wdata;

      // page byte only for data; code fetches keep 16-bit addressing
      if (in_addr)     hi_out <= is_xc ? op.addr[15:8] : op.addr[23:16];
      else if (in_mid) hi_out <= op.addr[15:8];

      psen_n <= !(in_data && is_xc);
      rd_n   <= !(in_data && is_rd);
      wr_n   <= !(in_data && is_wr);

      if (phase_q == PH_DATA && phase_d == PH_RESP && !is_wr) rsp_data <= lo_in;
      else if (phase_q == PH_IWAIT)                            rsp_data <= icode_rdata;
      else if (phase_q == PH_IDLE && phase_d == PH_RESP)       rsp_data <= NOP_BYTE;
    end
  end
endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
  import xbus_pkg::*;
#(
  parameter int                 ADDR_CYC = 2,
  parameter int                 TURN_CYC = 1,
  parameter int                 DATA_CYC = 3,
  parameter logic [15:0]        IROM_TOP = 16'hF7FF,
  parameter logic [7:0]         NOP_BYTE = 8'h00
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        strap_int,
  input  logic        fetch_req,
  input  logic [15:0] fetch_addr,
  input  logic        data_req,
  input  logic        data_we,
  input  logic [23:0] data_ptr,
  input  logic [7:0]  data_wdata,
  output logic        busy,
  output logic        rsp_valid,
  output logic [7:0]  rsp_data,
  output logic        icode_en,
  output logic [15:0] icode_addr,
  input  logic [7:0]  icode_rdata,
  output logic        ale,
  output logic [7:0]  lo_out,
  output logic        lo_oe,
  input  logic [7:0]  lo_in,
  output logic [7:0]  hi_out,
  output logic        rd_n,
  output logic        wr_n,
  output logic        psen_n
);
  logic        start, idle;
  xbus_op_t    op_new, op_q, op_nxt;
  xbus_phase_e phase_q, phase_d;

  xbus_req_arb #(.IROM_TOP(IROM_TOP)) u_arb (
    .clk(clk), .rst(rst), .strap_int(strap_int), .idle(idle),
    .fetch_req(fetch_req), .fetch_addr(fetch_addr),
    .data_req(data_req), .data_we(data_we), .data_ptr(data_ptr),
    .data_wdata(data_wdata), .start(start), .op(op_new)
  );

  xbus_seq #(.ADDR_CYC(ADDR_CYC), .TURN_CYC(TURN_CYC), .DATA_CYC(DATA_CYC)) u_seq (
    .clk(clk), .rst(rst), .start(start), .start_kind(op_new.kind),
    .phase_q(phase_q), .phase_d(phase_d), .idle(idle)
  );

  always_ff @(posedge clk) begin
    if (rst)        op_q <= '0;
    else if (start) op_q <= op_new;
  end

  assign op_nxt = start ? op_new : op_q;

  xbus_pins #(.NOP_BYTE(NOP_BYTE)) u_pins (
    .clk(clk), .rst(rst), .phase_q(phase_q), .phase_d(phase_d), .op(op_nxt),
    .lo_in(lo_in), .icode_rdata(icode_rdata), .busy(busy),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .icode_en(icode_en),
    .icode_addr(icode_addr), .ale(ale), .lo_out(lo_out), .lo_oe(lo_oe),
    .hi_out(hi_out), .rd_n(rd_n), .wr_n(wr_n), .psen_n(psen_n)
  );
endmodule

// File: rtl/xbus_ctrl_chk.sv
module xbus_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic busy,
  input logic rsp_valid,
  input logic icode_en,
  input logic ale,
  input logic lo_oe,
  input logic rd_n,
  input logic wr_n,
  input logic psen_n
);
  p_one_strobe_r7: assert property (@(posedge clk) disable iff (rst)
    $countones({~rd_n, ~wr_n, ~psen_n}) <= 1);

  p_no_strobe_in_ale_r7: assert property (@(posedge clk) disable iff (rst)
    ale |-> (rd_n && wr_n && psen_n));

  p_turn_before_read_r5: assert property (@(posedge clk) disable iff (rst)
    (!rd_n || !psen_n) |-> (!lo_oe && $past(!lo_oe)));

  p_write_drives_r6: assert property (@(posedge clk) disable iff (rst)
    !wr_n |-> lo_oe);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  p_irom_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    icode_en |-> (!ale && !lo_oe && psen_n));

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!ale && !lo_oe && rd_n && wr_n && psen_n && !rsp_valid));
endmodule

bind xbus_ctrl xbus_ctrl_chk i_chk (
  .clk(clk), .rst(rst), .busy(busy), .rsp_valid(rsp_valid),
  .icode_en(icode_en), .ale(ale), .lo_oe(lo_oe),
  .rd_n(rd_n), .wr_n(wr_n), .psen_n(psen_n)
);

// File: tb/test_xbus_ctrl.sv
module test_xbus_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int A_CYC = 2;
  localparam int T_CYC = 1;
  localparam int D_CYC = 3;

  typedef struct packed {
    logic busy, ale, oe, rd_n, wr_n, psen_n, ien, rv, chk_hi, chk_rd;
    logic [7:0]  lo, hi, rdat;
    logic [15:0] iaddr;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic strap_int = 1'b1;
  logic fetch_req = 1'b0, data_req = 1'b0, data_we = 1'b0;
  logic [15:0] fetch_addr = '0;
  logic [23:0] data_ptr = '0;
  logic [7:0]  data_wdata = '0, icode_rdata = 8'hEE, lo_in = 8'hEE;
  logic busy, rsp_valid, icode_en, ale, lo_oe, rd_n, wr_n, psen_n;
  logic [7:0]  rsp_data, lo_out, hi_out;
  logic [15:0] icode_addr;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  exp_t  q[$];
  string tq[$];
  logic [7:0] model_mem [int];
  logic [7:0] bus_mem   [int];
  logic strap_m = 1'b1;
  logic [7:0] lat_lo = '0, lat_pg = '0;
  logic ipend = 1'b0;
  logic [15:0] ipend_a = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xbus_ctrl i_xbus_ctrl (
    .clk(clk), .rst(rst), .strap_int(strap_int), .fetch_req(fetch_req),
    .fetch_addr(fetch_addr), .data_req(data_req), .data_we(data_we),
    .data_ptr(data_ptr), .data_wdata(data_wdata), .busy(busy),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .icode_en(icode_en),
    .icode_addr(icode_addr), .icode_rdata(icode_rdata), .ale(ale),
    .lo_out(lo_out), .lo_oe(lo_oe), .lo_in(lo_in), .hi_out(hi_out),
    .rd_n(rd_n), .wr_n(wr_n), .psen_n(psen_n)
  );

  function automatic logic [7:0] dpat(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ {a[22:16], 1'b1} ^ 8'h3C;
  endfunction
  function automatic logic [7:0] cpat(input logic [15:0] a);
    return a[7:0] + a[15:8] + 8'h11;
  endfunction
  function automatic logic [7:0] ipat(input logic [15:0] a);
    return ~a[7:0] ^ a[15:8];
  endfunction

  function automatic exp_t idle_e();
    exp_t e = '0;
    e.rd_n = 1'b1; e.wr_n = 1'b1; e.psen_n = 1'b1;
    return e;
  endfunction

  task automatic chk(input string fld, input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, fld, act, exp, $time);
    end
  endtask

  task automatic compare(input exp_t e, input string tag);
    chk("busy (R2)", tag, 16'(busy), 16'(e.busy));
    chk("ale (R3)", tag, 16'(ale), 16'(e.ale));
    chk("lo_oe (R5)", tag, 16'(lo_oe), 16'(e.oe));
    if (e.oe) chk("lo_out (R3 R6)", tag, 16'(lo_out), 16'(e.lo));
    if (e.chk_hi) chk("hi_out (R4)", tag, 16'(hi_out), 16'(e.hi));
    chk("strobes (R7)", tag, {13'd0, rd_n, wr_n, psen_n}, {13'd0, e.rd_n, e.wr_n, e.psen_n});
    chk("icode_en (R10)", tag, 16'(icode_en), 16'(e.ien));
    if (e.ien) chk("icode_addr (R10)", tag, icode_addr, e.iaddr);
    chk("rsp_valid (R8)", tag, 16'(rsp_valid), 16'(e.rv));
    if (e.chk_rd) chk("rsp_data (R8)", tag, 16'(rsp_data), 16'(e.rdat));
  endtask

  task automatic push(input exp_t e, input string tag);
    q.push_back(e); tq.push_back(tag);
  endtask

  // Behavioural schedule of the outputs for one accepted request
  task automatic plan(input logic f, input logic [15:0] fa, input logic d, input logic we,
                      input logic [23:0] dp, input logic [7:0] wd, input string tag);
    exp_t e;
    logic [23:0] a;
    int kind; // 0 ext fetch, 1 read, 2 write
    if (!d && strap_m) begin
      if (fa > 16'hF7FF) begin
        e = idle_e(); e.busy = 1; e.rv = 1; e.chk_rd = 1; e.rdat = 8'h00;
        push(e, tag);
      end else begin
        e = idle_e(); e.busy = 1; e.ien = 1; e.iaddr = fa; push(e, tag);
        e = idle_e(); e.busy = 1; push(e, tag);
        e = idle_e(); e.busy = 1; e.rv = 1; e.chk_rd = 1; e.rdat = ipat(fa); push(e, tag);
      end
      return;
    end
    if (d) begin a = dp; kind = we ? 2 : 1; end
    else   begin a = {8'h00, fa}; kind = 0; end
    for (int i = 0; i < A_CYC; i++) begin
      e = idle_e(); e.busy = 1; e.ale = 1; e.oe = 1; e.lo = a[7:0];
      e.chk_hi = 1; e.hi = (kind == 0) ? a[15:8] : a[23:16];
      push(e, tag);
    end
    for (int i = 0; i < T_CYC; i++) begin
      e = idle_e(); e.busy = 1; e.chk_hi = 1; e.hi = a[15:8]; push(e, tag);
    end
    for (int i = 0; i < D_CYC; i++) begin
      e = idle_e(); e.busy = 1; e.chk_hi = 1; e.hi = a[15:8];
      if (kind == 0) e.psen_n = 0;
      if (kind == 1) e.rd_n = 0;
      if (kind == 2) begin e.wr_n = 0; e.oe = 1; e.lo = wd; end
      push(e, tag);
    end
    e = idle_e(); e.busy = 1; e.rv = 1;
    if (kind == 0) begin e.chk_rd = 1; e.rdat = cpat(fa); end
    if (kind == 1) begin
      e.chk_rd = 1;
      e.rdat = model_mem.exists(int'(a)) ? model_mem[int'(a)] : dpat(a);
    end
    if (kind == 2) model_mem[int'(a)] = wd;
    push(e, tag);
  endtask

  // external latch, memories and on-chip code RAM, updated away from the edge
  task automatic bus_model();
    logic [23:0] da;
    if (ale) begin lat_lo = lo_out; lat_pg = hi_out; end
    da = {lat_pg, hi_out, lat_lo};
    if (!wr_n && lo_oe) bus_mem[int'(da)] = lo_out;
    if (!psen_n)    lo_in = cpat({hi_out, lat_lo});
    else if (!rd_n) lo_in = bus_mem.exists(int'(da)) ? bus_mem[int'(da)] : dpat(da);
    else            lo_in = 8'hEE;
    icode_rdata = ipend ? ipat(ipend_a) : 8'hEE;
    ipend = icode_en; ipend_a = icode_addr;
  endtask

  task automatic tick(input logic f, input logic [15:0] fa, input logic d, input logic we,
                      input logic [23:0] dp, input logic [7:0] wd, input string tag);
    exp_t e; string t;
    if (q.size() > 0) begin e = q.pop_front(); t = tq.pop_front(); end
    else begin e = idle_e(); t = "idle R2"; end
    compare(e, t);
    bus_model();
    fetch_req = f; fetch_addr = fa; data_req = d; data_we = we;
    data_ptr = dp; data_wdata = wd;
    if (!e.busy && (f || d)) plan(f, fa, d, we, dp, wd, tag);
    @(negedge clk);
  endtask

  task automatic idle_n(input int n);
    for (int i = 0; i < n; i++) tick(0, '0, 0, 0, '0, '0, "");
  endtask

  task automatic drain();
    while (q.size() > 0) idle_n(1);
    idle_n(1);
  endtask

  task automatic fetch(input logic [15:0] a, input string tag);
    tick(1, a, 0, 0, '0, '0, tag); drain();
  endtask

  task automatic dacc(input logic we, input logic [23:0] a, input logic [7:0] wd, input string tag);
    tick(0, '0, 1, we, a, wd, tag); drain();
  endtask

  task automatic do_reset(input logic s);
    rst = 1'b1; strap_int = s; strap_m = s;
    q.delete(); tq.delete();
    fetch_req = 0; data_req = 0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      compare(idle_e(), "R1 reset");
    end
    rst = 1'b0;
    @(negedge clk);
    compare(idle_e(), "R1 after reset");
  endtask

  initial begin
    @(negedge clk);
    // R9: strap high selects on-chip code
    do_reset(1'b1);
    fetch(16'h0000, "R10 fetch 0000");
    fetch(16'h1234, "R10 fetch 1234");
    fetch(16'hF7FF, "R10 top of on-chip space");
    fetch(16'hF800, "R11 first NOP address");
    fetch(16'hFFFF, "R11 last address");
    // R9: strap change after reset must not matter
    strap_int = 1'b0;
    fetch(16'h0100, "R9 strap ignored after reset");
    // R2: request while busy is dropped
    tick(1, 16'h0200, 0, 0, '0, '0, "R2 first");
    tick(0, '0, 1, 1, 24'h77_0000, 8'h99, "R2 dropped write");
    tick(1, 16'h0300, 0, 0, '0, '0, "R2 dropped fetch");
    drain();
    // R9: strap low selects external code
    do_reset(1'b0);
    fetch(16'h0000, "R9 R3 external fetch 0000");
    fetch(16'hABCD, "R3 external fetch ABCD");
    fetch(16'hF900, "R3 no NOP in external space");
    // R4 R5 R6 R8: page-addressed write, read back, unwritten read
    dacc(1'b1, 24'h12_3456, 8'hA5, "R6 write paged");
    dacc(1'b0, 24'h12_3456, 8'h00, "R4 R8 readback paged");
    dacc(1'b0, 24'h00_3456, 8'h00, "R4 other page unchanged");
    dacc(1'b0, 24'hFF_00FF, 8'h00, "R5 read unwritten");
    // R2: data beats fetch in the same cycle
    tick(1, 16'h4444, 1, 1, 24'h05_0607, 8'h3E, "R2 data priority");
    drain();
    dacc(1'b0, 24'h05_0607, 8'h00, "R2 priority readback");
    // back-to-back requests, each raised the first cycle busy is low
    for (int i = 0; i < 6; i++) begin
      tick(0, '0, 1, (i % 2) == 0, {8'(i * 37), 8'(i * 11), 8'(i * 5)}, 8'(i * 29 + 1), "R7 back to back");
      while (q.size() > 0) idle_n(1);
    end
    drain();
    for (int i = 0; i < 6; i += 2)
      dacc(1'b0, {8'(i * 37), 8'(i * 11), 8'(i * 5)}, 8'h00, "R8 back to back readback");
    idle_n(4);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule